// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port RAM

This block is a single-clock synchronous RAM with one write port and one read port. Its storage is organised in narrow rows of `ROW_W` bits. Each port may be widened by a power-of-two aggregate factor. A wide port carries several consecutive rows packed into one data word. A wide port's address counts groups of rows, not single rows. A typical use is a byte-wide producer filling a buffer that a word-wide consumer drains, or the reverse.

Lane `i` of a wide word sits at bits `[i*ROW_W +: ROW_W]` and maps to row `addr*AGG + i`. On the write port, each enable bit covers a group of `WR_GRAN` whole rows. When `WR_GRAN` equals the write aggregate, a single enable bit is broadcast to every lane. The read port has one enable and a one-cycle registered output.

Top module: `asym_dp_ram`

## Requirements
- R1: Each aggregate factor and `WR_GRAN` must be powers of two. `DEPTH` must be a multiple of each aggregate, with at least two groups per port, and `WR_GRAN` must divide `WR_AGG`; other values stop elaboration. A port's address is `clog2(DEPTH/AGG)` bits wide and its data is `ROW_W*AGG` bits wide; the write enable is `WR_AGG/WR_GRAN` bits wide.
- R2: On the read port, lane `i` of `rd_data` (bits `[i*ROW_W +: ROW_W]`) returns row `rd_addr*RD_AGG + i`.
- R3: On the write port, lane `i` of `wr_data` (bits `[i*ROW_W +: ROW_W]`) is stored to row `wr_addr*WR_AGG + i`.
- R4: With granular enables, lane `i` is written only when `wr_en[i/WR_GRAN]` is 1. Lanes whose enable bit is 0 keep their contents.
- R5: When every `wr_en` bit is 0, no row changes.
- R6: A read issued with `rd_en` high at a clock edge shows its data on `rd_data` right after that edge, a latency of one cycle.
- R7: While `rd_en` is low, `rd_data` holds its previous value, whatever the address and any write.
- R8: If a write and a read touch the same row at the same edge, the read returns the contents from before the write. The new value is visible to the next read.
- R9: While `rst_n` is low, `rd_data` is all zeros. Stored rows are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| wr_en | input | WR_AGG/WR_GRAN | Write enable, one bit per group of WR_GRAN rows |
| wr_addr | input | clog2(DEPTH/WR_AGG) | Write address in units of WR_AGG rows |
| wr_data | input | ROW_W*WR_AGG | Packed write lanes, lane 0 in the low bits |
| rd_en | input | 1 | Read enable |
| rd_addr | input | clog2(DEPTH/RD_AGG) | Read address in units of RD_AGG rows |
| rd_data | output | ROW_W*RD_AGG | Registered packed read lanes, lane 0 in the low bits |

## Verification
The bench fills every row of the default narrow-write, wide-read memory and reads back every wide address. A reversed lane order or a wrong address scaling would therefore show up as misplaced bytes. A second instance with a wide, granular write port and a narrow read port is swept through every enable pattern. That sweep exposes an enable bit steered to the wrong pair of lanes, or one that spills into a neighbouring group. A same-row write and read at one edge catches a design that forwards new data (R8). A write made while `rd_en` is low catches an output register that reloads without being enabled (R7).

// File: rtl/asym_dp_ram_pkg.sv
package asym_dp_ram_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic bit agg_legal(input int depth, input int agg);
      return is_pow2(agg) && (depth % agg == 0) && (depth / agg >= 2);
   endfunction

endpackage

// File: rtl/asym_dp_ram_wmask.sv
module asym_dp_ram_wmask #(
   parameter int WR_AGG  = 1,
   parameter int WR_GRAN = 1,
   localparam int EW     = WR_AGG / WR_GRAN
) (
   input  logic [EW-1:0]     grp_en,
   output logic [WR_AGG-1:0] lane_we
);
   generate
      if (EW == 1) begin : g_bcast
         assign lane_we = {WR_AGG{grp_en[0]}};
      end else begin : g_group
         for (genvar i = 0; i < WR_AGG; i++) begin : g_lane
            assign lane_we[i] = grp_en[i / WR_GRAN];
         end
      end
   endgenerate
endmodule

// File: rtl/asym_dp_ram_store.sv
module asym_dp_ram_store #(
   parameter int ROW_W  = 8,
   parameter int DEPTH  = 4096,
   parameter int WR_AGG = 1,
   parameter int RD_AGG = 4,
   localparam int RAW   = $clog2(DEPTH),
   localparam int RW1   = RAW + 1,
   localparam int WR_LG = $clog2(WR_AGG),
   localparam int RD_LG = $clog2(RD_AGG),
   localparam int WR_AW = $clog2(DEPTH / WR_AGG),
   localparam int RD_AW = $clog2(DEPTH / RD_AGG),
   localparam int WR_DW = ROW_W * WR_AGG,
   localparam int RD_DW = ROW_W * RD_AGG
) (
   input  logic              clk,
   input  logic [WR_AGG-1:0] lane_we,
   input  logic [WR_AW-1:0]  wr_addr,
   input  logic [WR_DW-1:0]  wr_data,
   input  logic [RD_AW-1:0]  rd_addr,
   output logic [RD_DW-1:0]  rd_word
);
   logic [ROW_W-1:0] mem [DEPTH];
   logic [RW1-1:0]   wrow [WR_AGG];
   logic [RW1-1:0]   rrow [RD_AGG];

   generate
      for (genvar i = 0; i < WR_AGG; i++) begin : g_wrow
         assign wrow[i] = (RW1'(wr_addr) << WR_LG) + RW1'(i);
      end
      for (genvar i = 0; i < RD_AGG; i++) begin : g_rrow
         assign rrow[i] = (RW1'(rd_addr) << RD_LG) + RW1'(i);
         assign rd_word[i*ROW_W +: ROW_W] =
            (rrow[i] < RW1'(DEPTH)) ? mem[rrow[i][RAW-1:0]] : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int i = 0; i < WR_AGG; i++) begin
         if (lane_we[i] && (wrow[i] < RW1'(DEPTH))) begin
            mem[wrow[i][RAW-1:0]] <= wr_data[i*ROW_W +: ROW_W];
         end
      end
   end
endmodule

// File: rtl/asym_dp_ram_rreg.sv
module asym_dp_ram_rreg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/asym_dp_ram.sv
module asym_dp_ram
   import asym_dp_ram_pkg::*;
#(
   parameter int ROW_W   = 8,
   parameter int DEPTH   = 4096,
   parameter int WR_AGG  = 1,
   parameter int WR_GRAN = 1,
   parameter int RD_AGG  = 4,
   localparam int WR_EW  = WR_AGG / WR_GRAN,
   localparam int WR_AW  = $clog2(DEPTH / WR_AGG),
   localparam int RD_AW  = $clog2(DEPTH / RD_AGG),
   localparam int WR_DW  = ROW_W * WR_AGG,
   localparam int RD_DW  = ROW_W * RD_AGG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WR_EW-1:0] wr_en,
   input  logic [WR_AW-1:0] wr_addr,
   input  logic [WR_DW-1:0] wr_data,
   input  logic             rd_en,
   input  logic [RD_AW-1:0] rd_addr,
   output logic [RD_DW-1:0] rd_data
);
   generate
      if (ROW_W < 1) begin : g_bad_row
         $error("asym_dp_ram: ROW_W must be at least 1");
      end
      if (!agg_legal(DEPTH, WR_AGG)) begin : g_bad_wagg
         $error("asym_dp_ram: WR_AGG must be a power of two dividing DEPTH into at least two groups");
      end
      if (!agg_legal(DEPTH, RD_AGG)) begin : g_bad_ragg
         $error("asym_dp_ram: RD_AGG must be a power of two dividing DEPTH into at least two groups");
      end
      if (!is_pow2(WR_GRAN) || (WR_GRAN > WR_AGG)) begin : g_bad_gran
         $error("asym_dp_ram: WR_GRAN must be a power of two no larger than WR_AGG");
      end
   endgenerate

   logic [WR_AGG-1:0] lane_we;
   logic [RD_DW-1:0]  rd_word;

   asym_dp_ram_wmask #(
      .WR_AGG (WR_AGG),
      .WR_GRAN(WR_GRAN)
   ) u_wmask (
      .grp_en (wr_en),
      .lane_we(lane_we)
   );

   asym_dp_ram_store #(
      .ROW_W (ROW_W),
      .DEPTH (DEPTH),
      .WR_AGG(WR_AGG),
      .RD_AGG(RD_AGG)
   ) u_store (
      .clk    (clk),
      .lane_we(lane_we),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_word(rd_word)
   );

   asym_dp_ram_rreg #(
      .DW(RD_DW)
   ) u_rreg (
      .clk  (clk),
      .rst_n(rst_n),
      .load (rd_en),
      .d    (rd_word),
      .q    (rd_data)
   );
endmodule

// File: rtl/asym_dp_ram_chk.sv
module asym_dp_ram_chk #(
   parameter int WR_EW   = 1,
   parameter int WR_AGG  = 1,
   parameter int WR_GRAN = 1,
   parameter int RD_AW   = 10,
   parameter int RD_DW   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WR_EW-1:0]  wr_en,
   input logic [WR_AGG-1:0] lane_we,
   input logic              rd_en,
   input logic [RD_AW-1:0]  rd_addr,
   input logic [RD_DW-1:0]  rd_data
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // R7: output register keeps its value while reads are disabled
   a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !rd_en) |=> $stable(rd_data));

   // R4: each enable bit opens exactly WR_GRAN lanes
   a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_we) == $countones(wr_en) * WR_GRAN);

   // R5: no enable bit, no lane write
   a_r5_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == '0) |-> (lane_we == '0));

   // R6: back-to-back reads of one address with no write between return the same word
   a_r6_repeat_read: assert property (@(posedge clk) disable iff (!rst_n)
      (live && rd_en && $past(rd_en) && (rd_addr == $past(rd_addr)) && ($past(wr_en) == '0))
      |=> (rd_data == $past(rd_data)));
endmodule

bind asym_dp_ram asym_dp_ram_chk #(
   .WR_EW  (WR_EW),
   .WR_AGG (WR_AGG),
   .WR_GRAN(WR_GRAN),
   .RD_AW  (RD_AW),
   .RD_DW  (RD_DW)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .lane_we(lane_we),
   .rd_en  (rd_en),
   .rd_addr(rd_addr),
   .rd_data(rd_data)
);

// File: tb/asym_dp_ram_test.sv
module asym_dp_ram_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // default: 8-bit rows, 4096 deep, narrow write, x4 read
   logic        a_wen;
   logic [11:0] a_waddr;
   logic [7:0]  a_wdata;
   logic        a_ren;
   logic [9:0]  a_raddr;
   logic [31:0] a_rdata;

   // swapped: 64 deep, x4 write with 2-row groups, narrow read
   logic [1:0]  b_wen;
   logic [3:0]  b_waddr;
   logic [31:0] b_wdata;
   logic        b_ren;
   logic [5:0]  b_raddr;
   logic [7:0]  b_rdata;

   asym_dp_ram uut (
      .clk(clk), .rst_n(rst_n), .wr_en(a_wen), .wr_addr(a_waddr), .wr_data(a_wdata),
      .rd_en(a_ren), .rd_addr(a_raddr), .rd_data(a_rdata));

   asym_dp_ram #(.ROW_W(8), .DEPTH(64), .WR_AGG(4), .WR_GRAN(2), .RD_AGG(1)) uut_sw (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wen), .wr_addr(b_waddr), .wr_data(b_wdata),
      .rd_en(b_ren), .rd_addr(b_raddr), .rd_data(b_rdata));

   logic [7:0] ref_a [4096];
   logic [7:0] ref_b [64];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wide_a(input int ga);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[j*8 +: 8] = ref_a[ga*4 + j];
      return w;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] old_w;
      a_wen = 0; a_waddr = 0; a_wdata = 0; a_ren = 0; a_raddr = 0;
      b_wen = 0; b_waddr = 0; b_wdata = 0; b_ren = 0; b_raddr = 0;
      rst_n = 0;
      step(); step();
      // R9: reset clears read data
      check(a_rdata === 32'd0, "R9 reset wide", a_rdata, 32'd0);
      check(b_rdata === 8'd0,  "R9 reset narrow", {24'd0, b_rdata}, 32'd0);
      // R1: derived port widths
      check($bits(uut.rd_addr) == 10 && $bits(uut.rd_data) == 32, "R1 default widths",
            $bits(uut.rd_addr), 10);
      check($bits(uut_sw.wr_en) == 2 && $bits(uut_sw.wr_addr) == 4 && $bits(uut_sw.wr_data) == 32,
            "R1 swapped widths", $bits(uut_sw.wr_en), 2);
      rst_n = 1;
      step();

      // R3 narrow write: fill every row
      for (int r = 0; r < 4096; r++) begin
         a_wen = 1; a_waddr = 12'(r); a_wdata = 8'($urandom);
         ref_a[r] = a_wdata;
         step();
      end
      a_wen = 0;
      // R2, R6: every wide address, data right after the capturing edge
      for (int g = 0; g < 1024; g++) begin
         a_ren = 1; a_raddr = 10'(g);
         step();
         check(a_rdata === wide_a(g), "R2 R6 wide read", a_rdata, wide_a(g));
      end

      // R7: disabled read holds while address moves and the row is rewritten
      old_w = a_rdata;
      a_ren = 0; a_raddr = 10'd3;
      a_wen = 1; a_waddr = 12'd4093; a_wdata = ~ref_a[4093]; ref_a[4093] = a_wdata;
      step();
      a_wen = 0;
      step();
      check(a_rdata === old_w, "R7 hold while disabled", a_rdata, old_w);

      // R5: write strobe low leaves row untouched
      a_wen = 0; a_waddr = 12'd17; a_wdata = ~ref_a[17];
      step();
      a_ren = 1; a_raddr = 10'd4;
      step();
      check(a_rdata === wide_a(4), "R5 idle write no effect", a_rdata, wide_a(4));

      // R8: same row written and read at one edge returns old data
      old_w = wide_a(5);
      a_wen = 1; a_waddr = 12'd22; a_wdata = ~ref_a[22];
      a_ren = 1; a_raddr = 10'd5;
      step();
      ref_a[22] = a_wdata;
      a_wen = 0;
      check(a_rdata === old_w, "R8 read before write", a_rdata, old_w);
      step();
      check(a_rdata === wide_a(5), "R8 new value next read", a_rdata, wide_a(5));
      a_ren = 0;

      // swapped config: full fill with both groups enabled (R3)
      for (int g = 0; g < 16; g++) begin
         b_wen = 2'b11; b_waddr = 4'(g); b_wdata = $urandom;
         for (int j = 0; j < 4; j++) ref_b[g*4 + j] = b_wdata[j*8 +: 8];
         step();
      end
      // R4: every enable pattern, lane i follows bit i/2
      for (int g = 0; g < 16; g++) begin
         b_wen = 2'(g); b_waddr = 4'(g); b_wdata = $urandom;
         for (int j = 0; j < 4; j++)
            if (b_wen[j/2]) ref_b[g*4 + j] = b_wdata[j*8 +: 8];
         step();
      end
      b_wen = 0;
      for (int r = 0; r < 64; r++) begin
         b_ren = 1; b_raddr = 6'(r);
         step();
         check(b_rdata === ref_b[r], "R3 R4 narrow read of wide write",
               {24'd0, b_rdata}, {24'd0, ref_b[r]});
      end
      b_ren = 0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule